// File: doc/BRIEF.md
# Synchronous Character Sync Receiver

This block turns a serial bit stream, handed over one bit per strobe by a line buffer, into parallel characters of 5, 6, 7 or 8 bits. It has no framing bits to work with, so it finds the character boundary on its own. It hunts for a fixed synchronizing code at every bit position. It locks only when that code shows up twice in a row, with the second copy aligned on the boundary set by the first.

After lock, each following group of N bits is handed out as one character, with a one-cycle valid pulse. Status outputs report the hunt progress and whether lock is held. A resync input, or the reset, drops the block back into the bit-by-bit hunt.

The first bit of each character lands in bit 0 of the output. Bits above the character length read as zero.

Top module: `sync_char_rx`

## Requirements
- R1: The first bit received of each character appears in char_out bit 0, later bits in rising order; bits at and above the character length read 0.
- R2: len_sel selects the character length N: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8.
- R3: While hunting, after every accepted bit the last N bits received (oldest in bit 0) are compared with the low N bits of the SYN code (default 8'h16). A match can occur at any bit offset, but only once at least N bits have arrived since the hunt began.
- R4: A first match moves syn_seq from 0 to 1 (encoding: 0 hunting, 1 one SYN seen, 2 locked).
- R5: If the N bits that follow the first match also equal the SYN code, sync_ok rises and syn_seq becomes 2 in the cycle after the last of those bits.
- R6: If those N bits differ from the SYN code, syn_seq returns to 0 and the bit-by-bit hunt resumes from the bits already received.
- R7: While locked, every run of N accepted bits yields one character, with char_vld high for exactly one cycle, in the cycle after the run's last bit.
- R8: No character is delivered before lock; the two SYN characters are not delivered either.
- R9: sync_ok stays high until reset or resync.
- R10: A resync pulse clears the hunt progress and the partial character, and it wins over a bit that completes a character in the same cycle. In the following cycle sync_ok=0, syn_seq=0 and char_vld=0.
- R11: len_sel is taken only while hunting; changes made while one SYN has been seen or while locked have no effect on the length.
- R12: bit_in is ignored while bit_vld is low.
- R13: After reset, sync_ok=0, syn_seq=0 and char_vld=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| resync | input | 1 | Synchronous request to drop lock and hunt again |
| len_sel | input | LEN_W | Character length select, N = MIN_LEN + len_sel |
| bit_vld | input | 1 | Bit strobe |
| bit_in | input | 1 | Serial data bit |
| char_out | output | MAX_W | Assembled character, first bit in bit 0 |
| char_vld | output | 1 | One-cycle pulse marking a new character |
| sync_ok | output | 1 | Character synchronization established |
| syn_seq | output | 2 | Hunt progress: 0 hunt, 1 one SYN seen, 2 locked |

## Verification
Two events can land in the same cycle: a resync request, and the strobe carrying the last bit of a character while locked. The bench drives both on the same edge, with no character expected on its scoreboard. It then judges the block on the next cycle: char_vld must stay low, and both sync_ok and syn_seq must read zero. The bench also drives a non-SYN character right after a first SYN, to confirm the fall back to the hunt. It then shows the sliding search picking up a new SYN from the bits that follow.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } rx_state_e;

endpackage

// File: rtl/sync_rx_window.sv
module sync_rx_window #(
  parameter int              MAX_W    = 8,
  parameter int              CNT_W    = 4,
  parameter logic [MAX_W-1:0] SYN_CODE = 'h16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] char_n,
  output logic [MAX_W-1:0] cand,
  output logic             is_syn
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_W);

  logic [MAX_W-1:0] win_q, win_d, win_nx, len_mask;
  logic [CNT_W-1:0] fill_q, fill_d, sh;
  logic             full;

  // the newest bit enters at the top; the last N bits sit right-aligned after the shift
  always_comb begin
    win_nx   = {bit_in, win_q[MAX_W-1:1]};
    sh       = MAX_C - char_n;
    cand     = win_nx >> sh;
    len_mask = {MAX_W{1'b1}} >> sh;
    full     = (fill_q >= (char_n - CNT_W'(1)));
    is_syn   = bit_vld && full && (cand == (SYN_CODE & len_mask));
  end

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    if (clr) begin
      win_d  = '0;
      fill_d = '0;
    end else if (bit_vld) begin
      win_d  = win_nx;
      fill_d = (fill_q == MAX_C) ? fill_q : fill_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !clr) |=> $stable(win_q)); // R12

  AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= MAX_C); // R3

endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import sync_rx_pkg::*;
#(
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             is_syn,
  input  logic [LEN_W-1:0] len_sel,
  output logic [CNT_W-1:0] char_n,
  output rx_state_e        state,
  output logic             emit
);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;
  logic [LEN_W-1:0] len_q, len_d;

  // length register follows the input only while hunting
  always_comb begin
    len_d = len_q;
    if (clr || state_q == ST_HUNT) len_d = len_sel;
  end

  assign char_n   = CNT_W'(MIN_LEN) + CNT_W'(len_q);
  assign last_idx = char_n - CNT_W'(1);
  assign state    = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    emit    = 1'b0;
    if (clr) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end else if (bit_vld) begin
      unique case (state_q)
        ST_HUNT: begin
          if (is_syn) begin
            state_d = ST_VERIFY;
            cnt_d   = '0;
          end
        end
        ST_VERIFY: begin
          if (cnt_q == last_idx) begin
            state_d = is_syn ? ST_LOCK : ST_HUNT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_LOCK: begin
          if (cnt_q == last_idx) begin
            emit  = 1'b1;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          state_d = ST_HUNT;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      len_q   <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  AST_SEQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'd3); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !clr) |=> state_q == ST_LOCK); // R9

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_HUNT && !clr) |=> $stable(len_q)); // R11

  AST_LOCK_VIA_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && $past(state_q) != ST_LOCK) |-> $past(state_q) == ST_VERIFY); // R5

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < char_n); // R7

  AST_CLR_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R10

endmodule

// File: rtl/sync_rx_out.sv
module sync_rx_out #(
  parameter int MAX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             emit,
  input  logic [MAX_W-1:0] cand,
  output logic [MAX_W-1:0] char_out,
  output logic             char_vld
);

  logic [MAX_W-1:0] data_q, data_d;
  logic             vld_q, vld_d;

  always_comb begin
    vld_d  = emit && !clr;
    data_d = data_q;
    if (vld_d) data_d = cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign char_out = data_q;
  assign char_vld = vld_q;

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R7

endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
  import sync_rx_pkg::*;
#(
  parameter  int               MIN_LEN  = 5,
  parameter  int               LEN_W    = 2,
  localparam int               MAX_W    = MIN_LEN + (1 << LEN_W) - 1,
  parameter  logic [MAX_W-1:0] SYN_CODE = 'h16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [MAX_W-1:0] char_out,
  output logic             char_vld,
  output logic             sync_ok,
  output logic [1:0]       syn_seq
);

  localparam int CNT_W = $clog2(MAX_W + 1);

  logic [1:0]       rst_pipe;
  logic             rst_i_n;
  logic [CNT_W-1:0] char_n;
  logic [MAX_W-1:0] cand;
  logic             is_syn;
  logic             emit;
  rx_state_e        state;

  // reset asserts at once, leaves two clock edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  sync_rx_window #(
    .MAX_W    (MAX_W),
    .CNT_W    (CNT_W),
    .SYN_CODE (SYN_CODE)
  ) u_window (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (resync),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .char_n  (char_n),
    .cand    (cand),
    .is_syn  (is_syn)
  );

  sync_rx_ctrl #(
    .MIN_LEN (MIN_LEN),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (resync),
    .bit_vld (bit_vld),
    .is_syn  (is_syn),
    .len_sel (len_sel),
    .char_n  (char_n),
    .state   (state),
    .emit    (emit)
  );

  sync_rx_out #(
    .MAX_W (MAX_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (resync),
    .emit     (emit),
    .cand     (cand),
    .char_out (char_out),
    .char_vld (char_vld)
  );

  assign sync_ok = (state == ST_LOCK);
  assign syn_seq = state;

  AST_VLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_i_n)
    char_vld |-> sync_ok); // R8

  AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_i_n)
    resync |=> (!sync_ok && syn_seq == 2'd0 && !char_vld)); // R10

  AST_IDLE_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bit_vld |=> !char_vld); // R12

endmodule

// File: tb/sync_char_rx_test.sv
`timescale 1ns/1ps
module sync_char_rx_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       resync;
  logic [1:0] len_sel;
  logic       bit_vld;
  logic       bit_in;
  logic [7:0] char_out;
  logic       char_vld;
  logic       sync_ok;
  logic [1:0] syn_seq;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   locked_f = 1'b0;
  bit   mon_on   = 1'b0;
  bit   done     = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  sync_char_rx uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .resync   (resync),
    .len_sel  (len_sel),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .char_out (char_out),
    .char_vld (char_vld),
    .sync_ok  (sync_ok),
    .syn_seq  (syn_seq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_vld = 1'b1;
    bit_in  = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] v, input int n);
    logic [7:0] m;
    m = 8'hFF >> (8 - n);
    if (locked_f) exp_q.push_back(v & m);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic pulse_resync();
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && char_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected char", int'(char_out), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(char_out == e, "R1 char value", int'(char_out), int'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R7: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; resync = 1'b0; len_sel = 2'd3; bit_vld = 1'b0; bit_in = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;
    check(sync_ok == 1'b0, "R13 sync_ok", sync_ok, 0);
    check(syn_seq == 2'd0, "R13 syn_seq", syn_seq, 0);
    check(char_vld == 1'b0, "R13 char_vld", char_vld, 0);

    // R3: SYN at an odd offset after three stray bits, length 8
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    check(syn_seq == 2'd0, "R3 no early match", syn_seq, 0);
    send_char(8'h16, 8);
    check(syn_seq == 2'd1, "R4 first SYN", syn_seq, 1);
    check(sync_ok == 1'b0, "R4 not yet locked", sync_ok, 0);
    send_char(8'h16, 8);
    check(sync_ok == 1'b1, "R5 locked", sync_ok, 1);
    check(syn_seq == 2'd2, "R5 syn_seq", syn_seq, 2);

    locked_f = 1'b1;
    send_char(8'hA5, 8);
    check(char_vld == 1'b1, "R7 vld timing", char_vld, 1);
    idle(1);
    check(char_vld == 1'b0, "R7 single pulse", char_vld, 0);
    send_char(8'h3C, 8);
    send_char(8'hFF, 8);
    send_char(8'h00, 8);
    idle(1);

    // R12: toggling data without strobe
    for (int i = 0; i < 6; i++) begin
      bit_in = i[0];
      @(negedge clk);
      check(char_vld == 1'b0, "R12 no strobe no char", char_vld, 0);
    end
    send_char(8'hC3, 8);
    idle(1);

    // R11: length change while locked is ignored
    len_sel = 2'd0;
    idle(2);
    send_char(8'h5A, 8);
    idle(1);
    check(sync_ok == 1'b1, "R9 sticky lock", sync_ok, 1);

    pulse_resync();
    locked_f = 1'b0;
    check(sync_ok == 1'b0, "R10 resync sync_ok", sync_ok, 0);
    check(syn_seq == 2'd0, "R10 resync syn_seq", syn_seq, 0);
    idle(2);

    // length 5: SYN then a wrong second character
    send_char(8'h16, 5);
    check(syn_seq == 2'd1, "R4 first SYN len5", syn_seq, 1);
    send_char(8'h01, 5);
    check(syn_seq == 2'd0, "R6 fallback", syn_seq, 0);
    check(sync_ok == 1'b0, "R6 not locked", sync_ok, 0);
    send_char(8'h16, 5);
    check(syn_seq == 2'd1, "R6 hunt resumed", syn_seq, 1);
    send_char(8'h16, 5);
    check(sync_ok == 1'b1, "R5 locked len5", sync_ok, 1);
    locked_f = 1'b1;
    send_char(8'h1B, 5);
    check(char_out == 8'h1B, "R2 len5 char upper zero", char_out, 8'h1B);
    send_char(8'h0A, 5);
    idle(2);

    // length 6, then resync landing on a completing bit
    pulse_resync();
    locked_f = 1'b0;
    len_sel = 2'd1;
    idle(2);
    send_char(8'h16, 6);
    send_char(8'h16, 6);
    check(sync_ok == 1'b1, "R2 locked len6", sync_ok, 1);
    locked_f = 1'b1;
    send_char(8'h2D, 6);
    idle(1);
    locked_f = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bit_vld = 1'b1; bit_in = 1'b1; resync = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0; resync = 1'b0;
    check(char_vld == 1'b0, "R10 resync beats last bit", char_vld, 0);
    check(sync_ok == 1'b0, "R10 lock dropped", sync_ok, 0);
    check(syn_seq == 2'd0, "R10 hunt state", syn_seq, 0);
    idle(4);
    check(exp_q.size() == 0, "R7 all chars delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule